// File: doc/BRIEF.md
# Gated-Enable Parallel Register with Three-State Output

This block is a parallel-load storage register of parameterised width. On each rising clock edge it takes in the data word, but only when both of its active-low load enables are low. If either load enable is high, it keeps the word it already holds. An active-high clear input empties the register at once, with no wait for a clock edge, and it overrides every other input.

The stored word goes out on a three-state bus. Two active-low output enables control that bus, and it is driven only while both of them are low. The output side is fully separate from the storage side. The output enables never change what is loaded, held or cleared. A word clocked in while the bus is released shows up as soon as the bus is enabled.

The block also brings out a plain drive-enable signal. It lets a checker see the released bus state without relying on tristate resolution. Every pin is a plain control or data pin. The register has no flow control at its edge, so there is no back-pressure to describe.

Top module: `gated_load_register`

## Requirements
- R1: On a rising clock edge, with clear low and both load enables (`ld_n_a`, `ld_n_b`) low, the register stores `din`.
- R2: On a rising clock edge where either load enable is high, the stored word keeps its previous value.
- R3: While `clr` is high, the stored word is zero. The clear takes effect immediately, without waiting for a clock edge.
- R4: When `clr` is high at a rising clock edge that also has both load enables low, the register reads zero after that edge.
- R5: After `clr` is released, the register stays at zero until the first rising edge with both load enables low.
- R6: `drive_en` is 1 exactly when both output enables (`oe_n_a`, `oe_n_b`) are low. While `drive_en` is 1, `q_bus` carries the stored word. Otherwise every bit of `q_bus` is high impedance.
- R7: The output enables do not affect storage. A word loaded while `drive_en` is 0 appears on `q_bus` in the same cycle that the output enables both go low.
- R8: `din` and the load enables are sampled only at the rising clock edge. Changes between edges leave the stored word unchanged.
- R9: The width is the parameter `WIDTH`, with a default of 4 bits. The load gating and the output gating are the same for every bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; storage acts on its rising edge |
| clr | input | 1 | Asynchronous clear, active high |
| ld_n_a | input | 1 | First load enable, active low |
| ld_n_b | input | 1 | Second load enable, active low |
| oe_n_a | input | 1 | First output enable, active low |
| oe_n_b | input | 1 | Second output enable, active low |
| din | input | WIDTH | Parallel data word to load |
| q_bus | output | WIDTH | Three-state output bus carrying the stored word |
| drive_en | output | 1 | High while `q_bus` is actively driven |

## Verification
On every cycle, the assertions check the following:
- The word after each qualifying edge equals the data sampled at that edge.
- The word is stable across non-qualifying edges.
- The word is zero while clear is high.
- The driven bus always matches the stored word, and it is released whenever an output enable is high.

Some behaviours can only be shown by the bench's scenarios:
- The clear acting in the middle of a cycle.
- The clear winning over a simultaneous load.
- A word loaded behind a released bus appearing later.
- Glitches on data and load enables between edges having no effect.

The bench sweeps every data value against every load-enable and output-enable combination.

// File: rtl/gated_reg_pkg.sv
package gated_reg_pkg;

  localparam int unsigned DEFAULT_WIDTH = 4;

  // Combine two active-low enables into one active-high qualifier.
  function automatic logic both_low(input logic a_n, input logic b_n);
    return ~(a_n | b_n);
  endfunction

endpackage

// File: rtl/grl_enable_nor.sv
module grl_enable_nor
  import gated_reg_pkg::*;
(
  input  logic en_n_a,
  input  logic en_n_b,
  output logic qualified
);

  always_comb qualified = both_low(en_n_a, en_n_b);

endmodule

// File: rtl/grl_store_bank.sv
module grl_store_bank #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  // One flop per bit. Every bit shares the same load and clear gating.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or posedge clr) begin
      if (clr)       q[b] <= 1'b0;
      else if (load) q[b] <= d[b];
    end
  end

endmodule

// File: rtl/grl_bus_driver.sv
module grl_bus_driver #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             enable,
  input  logic [WIDTH-1:0] word,
  output wire  [WIDTH-1:0] bus
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_drv
    assign bus[b] = enable ? word[b] : 1'bz;
  end

endmodule

// File: rtl/gated_load_register.sv
module gated_load_register
  import gated_reg_pkg::*;
#(
  parameter int unsigned WIDTH = DEFAULT_WIDTH
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             ld_n_a,
  input  logic             ld_n_b,
  input  logic             oe_n_a,
  input  logic             oe_n_b,
  input  logic [WIDTH-1:0] din,
  output wire  [WIDTH-1:0] q_bus,
  output logic             drive_en
);

  logic             load_ok;
  logic [WIDTH-1:0] stored;

  grl_enable_nor u_load_gate (
    .en_n_a    (ld_n_a),
    .en_n_b    (ld_n_b),
    .qualified (load_ok)
  );

  grl_enable_nor u_out_gate (
    .en_n_a    (oe_n_a),
    .en_n_b    (oe_n_b),
    .qualified (drive_en)
  );

  grl_store_bank #(.WIDTH(WIDTH)) u_bank (
    .clk  (clk),
    .clr  (clr),
    .load (load_ok),
    .d    (din),
    .q    (stored)
  );

  grl_bus_driver #(.WIDTH(WIDTH)) u_drv (
    .enable (drive_en),
    .word   (stored),
    .bus    (q_bus)
  );

endmodule

// File: rtl/gated_load_register_checker.sv
module gated_load_register_checker #(
  parameter int unsigned WIDTH = 4
) (
  input logic             clk,
  input logic             clr,
  input logic             ld_n_a,
  input logic             ld_n_b,
  input logic             oe_n_a,
  input logic             oe_n_b,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] stored,
  input logic [WIDTH-1:0] q_bus,
  input logic             drive_en
);

  assert_load_R1: assert property (@(posedge clk) disable iff (clr)
    ($past(!ld_n_a && !ld_n_b) && !$past(clr)) |-> stored == $past(din))
    else $error("R1 load mismatch");

  assert_hold_R2: assert property (@(posedge clk) disable iff (clr)
    ($past(ld_n_a || ld_n_b) && !$past(clr)) |-> $stable(stored))
    else $error("R2 hold violated");

  // R3 and R4: the word is zero whenever clear is high, including at a load edge.
  always_ff @(negedge clk) begin
    if (clr) begin
      assert_clear_R3: assert (stored == '0) else $error("R3 clear not zero");
    end
  end

  assert_bus_word_R6: assert property (@(posedge clk) disable iff (clr)
    drive_en |-> q_bus == stored)
    else $error("R6 bus does not match word");

  assert_bus_release_R6: assert property (@(posedge clk) disable iff (clr)
    (oe_n_a || oe_n_b) |-> !drive_en)
    else $error("R6 bus driven while disabled");

endmodule

bind gated_load_register gated_load_register_checker #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .clr      (clr),
  .ld_n_a   (ld_n_a),
  .ld_n_b   (ld_n_b),
  .oe_n_a   (oe_n_a),
  .oe_n_b   (oe_n_b),
  .din      (din),
  .stored   (stored),
  .q_bus    (q_bus),
  .drive_en (drive_en)
);

// File: tb/gated_load_register_bench.sv
module gated_load_register_bench;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         clr = 1'b1;
  logic         ld_n_a = 1'b1, ld_n_b = 1'b1;
  logic         oe_n_a = 1'b1, oe_n_b = 1'b1;
  logic [W-1:0] din = '0;
  wire  [W-1:0] q_bus;
  logic         drive_en;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  gated_load_register u_gated_load_register (
    .clk (clk), .clr (clr),
    .ld_n_a (ld_n_a), .ld_n_b (ld_n_b),
    .oe_n_a (oe_n_a), .oe_n_b (oe_n_b),
    .din (din), .q_bus (q_bus), .drive_en (drive_en)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Enable the bus, let it settle, and compare the word (R6 and R7 path).
  task automatic read_word(input string req, input logic [W-1:0] exp);
    oe_n_a = 1'b0; oe_n_b = 1'b0;
    #1;
    check(req, int'(drive_en), 1);
    check(req, int'(q_bus), int'(exp));
    oe_n_a = 1'b1; oe_n_b = 1'b1;
  endtask

  // One clock edge: inputs are already set at the negedge, and the check comes at the next negedge.
  task automatic edge_step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    // R3: the word reads zero while clear is held.
    read_word("R3 reset", '0);
    edge_step();
    // R5: release clear with no load, and the word stays zero.
    clr = 1'b0;
    edge_step();
    read_word("R5 zero after release", '0);

    // R1 R2 R6 R7: sweep every data value against every load and output enable pair.
    for (int d = 0; d < (1 << W); d++) begin
      for (int l = 0; l < 4; l++) begin
        logic [W-1:0] prev;
        prev = W'(~d);
        din = prev; ld_n_a = 1'b0; ld_n_b = 1'b0;
        edge_step();
        din = W'(d); ld_n_a = l[0]; ld_n_b = l[1];
        oe_n_a = l[1]; oe_n_b = l[0];
        #1;
        // R6: the drive enable follows the NOR of the output enables.
        check("R6 drive_en", int'(drive_en), (l == 0) ? 1 : 0);
        edge_step();
        ld_n_a = 1'b1; ld_n_b = 1'b1;
        if (l == 0) read_word("R1 load", W'(d));
        else        read_word("R2 hold", prev);
      end
    end

    // R7: load while the bus is released, then enable it.
    oe_n_a = 1'b1; oe_n_b = 1'b0;
    din = 4'hA; ld_n_a = 1'b0; ld_n_b = 1'b0;
    edge_step();
    ld_n_a = 1'b1; ld_n_b = 1'b1;
    check("R7 released", int'(drive_en), 0);
    read_word("R7 appears on enable", 4'hA);

    // R8: glitches on data and load enables between edges are ignored.
    din = 4'h5; ld_n_a = 1'b0; ld_n_b = 1'b0;
    @(posedge clk); #2;
    din = 4'h9; ld_n_a = 1'b1;
    @(negedge clk);
    read_word("R8 sampled value", 4'h5);
    din = 4'h3; ld_n_a = 1'b1; ld_n_b = 1'b0;
    @(posedge clk); #2;
    ld_n_a = 1'b0;
    #1 ld_n_a = 1'b1;
    @(negedge clk);
    read_word("R8 mid-cycle enable pulse", 4'h5);

    // R3: a clear raised mid-cycle acts before the next edge.
    #2 clr = 1'b1;
    read_word("R3 async clear", '0);
    @(negedge clk);
    clr = 1'b0;
    edge_step();
    read_word("R5 holds zero", '0);

    // R4: clear wins over a load on the same edge.
    din = 4'hF; ld_n_a = 1'b0; ld_n_b = 1'b0; clr = 1'b1;
    edge_step();
    read_word("R4 clear wins", '0);
    ld_n_a = 1'b1; ld_n_b = 1'b1; clr = 1'b0;
    edge_step();
    read_word("R5 zero until load", '0);
    din = 4'h6; ld_n_a = 1'b0; ld_n_b = 1'b0;
    edge_step();
    ld_n_a = 1'b1; ld_n_b = 1'b1;
    read_word("R5 first load", 4'h6);

    // R9: the default width is four bits.
    check("R9 width", $bits(q_bus), 4);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule